// File: doc/BRIEF.md
# I2C Master SCL Phase and SDA Timing Generator

This block produces the serial clock for an I2C master and the two timing strobes that the byte engine around it needs. The engine holds `run` high while it wants clock periods. The generator then drives SCL low for a programmed low phase and releases it. It waits until the line is really high, which is how a slave that stretches the clock holds it off, and then times the high phase. During each low phase it raises a one-cycle strobe marking when SDA may change. During each high phase it raises a one-cycle strobe marking when SDA should be sampled.

All counting is in cycles of the peripheral clock. Three pairs of high and low counts are provided, one pair per speed mode, and a two-bit speed field chooses between them. Each count is an offset value: the high phase is eight cycles longer than its count and the low phase is one cycle longer than its count. A count below its floor is treated as the floor. The SDA hold delay is the hold value plus two cycles. The sample delay is the setup value minus one cycle. Lengths and delays are captured when a phase begins, so software may rewrite a count while transfers are running.

Top module: `i2c_scl_timer`

## Requirements
- R1: Out of reset and whenever `run` has been low since the last finished period, `scl_out` is 1 (released) and neither `sda_change_tick` nor `sample_tick` pulses.
- R2: `speed_mode` 1 selects the standard pair (`std_hi`, `std_lo`), 2 selects the fast pair, and 3 selects the high-speed pair. Value 0 is treated as standard.
- R3: Each SCL low phase (`scl_out` = 0) lasts max(low count, 8) + 1 clock cycles.
- R4: With no stretching, each SCL high phase (`scl_out` = 1 between two low phases) lasts max(high count, 6) + 8 cycles.
- R5: `sda_change_tick` pulses once per low phase, at offset min(hold + 2, low length − 1), where offset 0 is the first cycle with `scl_out` = 0.
- R6: `sample_tick` pulses once per high phase, at offset min(max(setup − 1, 0), high length − 1), counted from the first cycle in which `scl_in` is seen high.
- R7: The high-phase count starts only when `scl_in` is seen high. If a slave holds `scl_in` low for N cycles after release, SCL stays released for N + high length cycles and `sample_tick` moves later by N.
- R8: A count changed during a phase does not alter that phase. It takes effect from the next phase that loads it.
- R9: When `run` falls, the current period completes, SCL is left released, and no further low phase or strobe occurs until `run` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Byte engine request for clock periods |
| speed_mode | input | 2 | Speed field: 1 standard, 2 fast, 3 high speed, 0 as standard |
| std_hi | input | CNT_W | Standard high-phase count |
| std_lo | input | CNT_W | Standard low-phase count |
| fast_hi | input | CNT_W | Fast high-phase count |
| fast_lo | input | CNT_W | Fast low-phase count |
| hs_hi | input | CNT_W | High-speed high-phase count |
| hs_lo | input | CNT_W | High-speed low-phase count |
| sda_hold | input | HOLD_W | SDA hold value (delay = value + 2) |
| sda_setup | input | SETUP_W | SDA setup value (delay = value − 1, floor 0) |
| scl_in | input | 1 | Observed SCL bus level |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_change_tick | output | 1 | One-cycle strobe: SDA may change |
| sample_tick | output | 1 | One-cycle strobe: sample SDA |

## Verification
The bench programs counts below their floors. A design that skips the clamp gives low phases shorter than 9 cycles or high phases shorter than 14. It sets hold and setup values larger than the phase they fall in. A design that does not clamp them loses the strobe for that period. It stretches the released clock by a random number of cycles. A design that counts from the release instead of from the observed high ends the high phase early and fires the sample strobe too soon. Directed cases rewrite a low count in the middle of a low phase, which exposes a design that reloads continuously. They use speed value 0, and they drop `run` to show that SCL parks released with no stray strobes.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOW   = 2'd1,
        PH_WAITH = 2'd2,
        PH_HIGH  = 2'd3
    } phase_e;

    localparam int LO_FLOOR  = 8;
    localparam int HI_FLOOR  = 6;
    localparam int LO_EXTRA  = 1;
    localparam int HI_EXTRA  = 8;
    localparam int HOLD_EXTRA = 2;
    localparam int NUM_MODES = 3;
endpackage

// File: rtl/i2c_scl_cfg_sel.sv
module i2c_scl_cfg_sel
    import i2c_scl_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int HOLD_W  = 16,
    parameter int SETUP_W = 8,
    parameter int LEN_W   = 18
) (
    input  logic [1:0]                       speed_mode,
    input  logic [NUM_MODES-1:0][CNT_W-1:0]  hi_cnt,
    input  logic [NUM_MODES-1:0][CNT_W-1:0]  lo_cnt,
    input  logic [HOLD_W-1:0]                sda_hold,
    input  logic [SETUP_W-1:0]               sda_setup,
    output logic [LEN_W-1:0]                 lo_len,
    output logic [LEN_W-1:0]                 lo_tgt,
    output logic [LEN_W-1:0]                 hi_len,
    output logic [LEN_W-1:0]                 hi_tgt
);
    logic [LEN_W-1:0] hi_len_m [NUM_MODES];
    logic [LEN_W-1:0] lo_len_m [NUM_MODES];

    // Floor and offset for each mode's pair.
    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        logic [LEN_W-1:0] hi_w, lo_w;
        assign hi_w = LEN_W'(hi_cnt[g]);
        assign lo_w = LEN_W'(lo_cnt[g]);
        assign hi_len_m[g] = ((hi_w < LEN_W'(HI_FLOOR)) ? LEN_W'(HI_FLOOR) : hi_w) + LEN_W'(HI_EXTRA);
        assign lo_len_m[g] = ((lo_w < LEN_W'(LO_FLOOR)) ? LEN_W'(LO_FLOOR) : lo_w) + LEN_W'(LO_EXTRA);
    end

    logic [LEN_W-1:0] hold_dly, setup_dly;

    always_comb begin
        case (speed_mode)
            2'd2:    begin hi_len = hi_len_m[1]; lo_len = lo_len_m[1]; end
            2'd3:    begin hi_len = hi_len_m[2]; lo_len = lo_len_m[2]; end
            default: begin hi_len = hi_len_m[0]; lo_len = lo_len_m[0]; end
        endcase
        hold_dly  = LEN_W'(sda_hold) + LEN_W'(HOLD_EXTRA);
        setup_dly = (sda_setup == '0) ? '0 : LEN_W'(sda_setup) - LEN_W'(1);
        lo_tgt = (hold_dly  > lo_len - LEN_W'(1)) ? lo_len - LEN_W'(1) : hold_dly;
        hi_tgt = (setup_dly > hi_len - LEN_W'(1)) ? hi_len - LEN_W'(1) : setup_dly;
    end

    always_comb begin
        assert_len_floor_R3: assert (lo_len >= LEN_W'(LO_FLOOR + LO_EXTRA));
        assert_len_floor_R4: assert (hi_len >= LEN_W'(HI_FLOOR + HI_EXTRA));
    end
endmodule

// File: rtl/i2c_scl_phase_seq.sv
module i2c_scl_phase_seq
    import i2c_scl_pkg::*;
#(
    parameter int LEN_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             scl_in,
    input  logic [LEN_W-1:0] lo_len,
    input  logic [LEN_W-1:0] lo_tgt,
    input  logic [LEN_W-1:0] hi_len,
    input  logic [LEN_W-1:0] hi_tgt,
    output logic             scl_out,
    output logic             sda_change_tick,
    output logic             sample_tick
);
    typedef struct packed {
        phase_e           ph;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] tgt;
    } seq_t;

    seq_t s_q, s_d;
    logic last_q;

    assign last_q = (s_q.cnt == s_q.len - LEN_W'(1));

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE: begin
                if (run) begin
                    s_d.ph  = PH_LOW;
                    s_d.cnt = '0;
                    s_d.len = lo_len;
                    s_d.tgt = lo_tgt;
                end
            end
            PH_LOW: begin
                if (last_q) begin
                    s_d.ph  = PH_WAITH;
                    s_d.cnt = '0;
                    s_d.len = hi_len;
                    s_d.tgt = hi_tgt;
                end else begin
                    s_d.cnt = s_q.cnt + LEN_W'(1);
                end
            end
            PH_WAITH: begin
                // The cycle the line is seen high is high-phase cycle 0.
                if (scl_in) begin
                    s_d.ph  = PH_HIGH;
                    s_d.cnt = LEN_W'(1);
                end
            end
            default: begin
                if (last_q) begin
                    if (run) begin
                        s_d.ph  = PH_LOW;
                        s_d.cnt = '0;
                        s_d.len = lo_len;
                        s_d.tgt = lo_tgt;
                    end else begin
                        s_d.ph  = PH_IDLE;
                        s_d.cnt = '0;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + LEN_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, len: '0, tgt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_out         = (s_q.ph != PH_LOW);
    assign sda_change_tick = (s_q.ph == PH_LOW) && (s_q.cnt == s_q.tgt);
    assign sample_tick     = ((s_q.ph == PH_WAITH) && scl_in && (s_q.tgt == '0)) ||
                             ((s_q.ph == PH_HIGH) && (s_q.cnt == s_q.tgt));

    assert_tick_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_change_tick && sample_tick));

    assert_sda_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change_tick |-> !scl_out);

    assert_sample_seen_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> (scl_out && scl_in));

    assert_low_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_LOW && s_d.ph != PH_LOW) |-> (s_q.cnt >= LEN_W'(LO_FLOOR)));

    assert_stretch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_WAITH && !scl_in) |=> (s_q.ph == PH_WAITH && scl_out));

    assert_idle_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && !run) |=> (scl_out && !sda_change_tick && !sample_tick));

    assert_phase_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_LOW && !last_q) |=> $stable(s_q.len));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int HOLD_W  = 16,
    parameter int SETUP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [1:0]         speed_mode,
    input  logic [CNT_W-1:0]   std_hi,
    input  logic [CNT_W-1:0]   std_lo,
    input  logic [CNT_W-1:0]   fast_hi,
    input  logic [CNT_W-1:0]   fast_lo,
    input  logic [CNT_W-1:0]   hs_hi,
    input  logic [CNT_W-1:0]   hs_lo,
    input  logic [HOLD_W-1:0]  sda_hold,
    input  logic [SETUP_W-1:0] sda_setup,
    input  logic               scl_in,
    output logic               scl_out,
    output logic               sda_change_tick,
    output logic               sample_tick
);
    localparam int BASE_W = (CNT_W > HOLD_W) ? CNT_W : HOLD_W;
    localparam int LEN_W  = BASE_W + 2;

    logic [NUM_MODES-1:0][CNT_W-1:0] hi_cnt, lo_cnt;
    logic [LEN_W-1:0] lo_len, lo_tgt, hi_len, hi_tgt;

    assign hi_cnt = {hs_hi, fast_hi, std_hi};
    assign lo_cnt = {hs_lo, fast_lo, std_lo};

    i2c_scl_cfg_sel #(
        .CNT_W(CNT_W), .HOLD_W(HOLD_W), .SETUP_W(SETUP_W), .LEN_W(LEN_W)
    ) u_cfg (
        .speed_mode(speed_mode),
        .hi_cnt(hi_cnt),
        .lo_cnt(lo_cnt),
        .sda_hold(sda_hold),
        .sda_setup(sda_setup),
        .lo_len(lo_len),
        .lo_tgt(lo_tgt),
        .hi_len(hi_len),
        .hi_tgt(hi_tgt)
    );

    i2c_scl_phase_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .run(run),
        .scl_in(scl_in),
        .lo_len(lo_len),
        .lo_tgt(lo_tgt),
        .hi_len(hi_len),
        .hi_tgt(hi_tgt),
        .scl_out(scl_out),
        .sda_change_tick(sda_change_tick),
        .sample_tick(sample_tick)
    );

    assert_mode_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_mode == 2'd0) |-> (lo_len == ((std_lo < CNT_W'(LO_FLOOR)) ? LEN_W'(LO_FLOOR + LO_EXTRA)
                                              : LEN_W'(std_lo) + LEN_W'(LO_EXTRA))));
endmodule

// File: tb/sim_i2c_scl_timer.sv
module sim_i2c_scl_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  speed_mode = 2'd1;
    logic [15:0] std_hi = 16'd10, std_lo = 16'd10, fast_hi = 16'd10, fast_lo = 16'd10;
    logic [15:0] hs_hi = 16'd10, hs_lo = 16'd10;
    logic [15:0] sda_hold = 16'd0;
    logic [7:0]  sda_setup = 8'd0;
    logic        scl_in, scl_out, sda_change_tick, sample_tick;
    logic [7:0]  rel_cnt = 8'd0;
    int          stretch = 0;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    // Slave model: holds SCL low for 'stretch' cycles after release.
    always @(posedge clk) begin
        if (!scl_out) rel_cnt <= 8'd0;
        else if (rel_cnt != 8'd255) rel_cnt <= rel_cnt + 8'd1;
    end
    assign scl_in = scl_out && (int'(rel_cnt) >= stretch);

    i2c_scl_timer u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .speed_mode(speed_mode),
        .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
        .hs_hi(hs_hi), .hs_lo(hs_lo), .sda_hold(sda_hold), .sda_setup(sda_setup),
        .scl_in(scl_in), .scl_out(scl_out), .sda_change_tick(sda_change_tick),
        .sample_tick(sample_tick)
    );

    function automatic int exp_lo(int v);
        return ((v < 8) ? 8 : v) + 1;
    endfunction
    function automatic int exp_hi(int v);
        return ((v < 6) ? 6 : v) + 8;
    endfunction
    function automatic int exp_sda(int hold, int lo_len);
        return (hold + 2 > lo_len - 1) ? lo_len - 1 : hold + 2;
    endfunction
    function automatic int exp_smp(int setup, int hi_len);
        int d;
        d = (setup == 0) ? 0 : setup - 1;
        return (d > hi_len - 1) ? hi_len - 1 : d;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Measures one full period starting at the next SCL fall.
    task automatic measure(output int lo, output int hi, output int sda_off, output int smp_off);
        while (scl_out !== 1'b1) @(negedge clk);
        while (scl_out !== 1'b0) @(negedge clk);
        lo = 0; sda_off = -1;
        while (scl_out === 1'b0) begin
            if (sda_change_tick && sda_off < 0) sda_off = lo;
            lo++;
            @(negedge clk);
        end
        hi = 0; smp_off = -1;
        while (scl_out === 1'b1) begin
            if (sample_tick && smp_off < 0) smp_off = hi;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        int lo, hi, so, mo, ticks, falls, mode, idx, l, h;
        int hv [4];
        int lv [4];
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset and idle state.
        chk("R1 scl_out after reset", int'(scl_out), 1);
        ticks = 0; falls = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!scl_out) falls++;
            if (sda_change_tick || sample_tick) ticks++;
        end
        chk("R1 idle low cycles", falls, 0);
        chk("R1 idle strobes", ticks, 0);

        // Directed: below-floor counts, standard mode.
        std_lo = 16'd3; std_hi = 16'd2; sda_hold = 16'd1; sda_setup = 8'd4;
        run = 1'b1;
        measure(lo, hi, so, mo);
        chk("R3 clamped low", lo, 9);
        chk("R4 clamped high", hi, 14);
        chk("R5 sda offset", so, 3);
        chk("R6 sample offset", mo, 3);

        // Directed: speed value 0 uses the standard pair.
        @(negedge clk);
        speed_mode = 2'd0; std_lo = 16'd20; std_hi = 16'd15;
        fast_lo = 16'd30; hs_lo = 16'd35;
        measure(lo, hi, so, mo);
        measure(lo, hi, so, mo);
        chk("R2 mode0 low", lo, 21);
        chk("R2 mode0 high", hi, 23);

        // Directed R8: rewrite the low count inside a low phase.
        speed_mode = 2'd1;
        measure(lo, hi, so, mo);
        while (scl_out !== 1'b1) @(negedge clk);
        while (scl_out !== 1'b0) @(negedge clk);
        std_lo = 16'd30;
        l = 0;
        while (scl_out === 1'b0) begin l++; @(negedge clk); end
        chk("R8 current low keeps old", l, 21);
        measure(lo, hi, so, mo);
        chk("R8 next low uses new", lo, 31);

        // Random trials.
        for (int t = 0; t < 30; t++) begin
            @(negedge clk);
            mode = $urandom_range(0, 3);
            for (int k = 1; k < 4; k++) begin
                hv[k] = $urandom_range(0, 40);
                lv[k] = $urandom_range(0, 40);
            end
            std_hi = 16'(hv[1]); std_lo = 16'(lv[1]);
            fast_hi = 16'(hv[2]); fast_lo = 16'(lv[2]);
            hs_hi = 16'(hv[3]); hs_lo = 16'(lv[3]);
            sda_hold = 16'($urandom_range(0, 50));
            sda_setup = 8'($urandom_range(0, 60));
            stretch = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 12);
            speed_mode = 2'(mode);
            idx = (mode == 0) ? 1 : mode;
            l = exp_lo(lv[idx]);
            h = exp_hi(hv[idx]);
            measure(lo, hi, so, mo);
            measure(lo, hi, so, mo);
            chk("R2 R3 random low", lo, l);
            chk("R4 R7 random high", hi, stretch + h);
            chk("R5 random sda offset", so, exp_sda(int'(sda_hold), l));
            chk("R6 R7 random sample offset", mo, stretch + exp_smp(int'(sda_setup), h));
        end

        // R9: drop run and confirm SCL parks released.
        stretch = 0;
        while (scl_out !== 1'b0) @(negedge clk);
        run = 1'b0;
        repeat (200) @(negedge clk);
        ticks = 0; falls = 0;
        for (int i = 0; i < 200; i++) begin
            if (!scl_out) falls++;
            if (sda_change_tick || sample_tick) ticks++;
            @(negedge clk);
        end
        chk("R9 parked low cycles", falls, 0);
        chk("R9 parked strobes", ticks, 0);

        // Restart after stop.
        speed_mode = 2'd3; hs_lo = 16'd12; hs_hi = 16'd9; sda_hold = 16'd0; sda_setup = 8'd1;
        run = 1'b1;
        measure(lo, hi, so, mo);
        chk("R3 restart low", lo, 13);
        chk("R4 restart high", hi, 17);
        chk("R6 restart sample offset", mo, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule